// File: doc/BRIEF.md
# Motor Driver Fault Supervisor

This block is the digital protection controller for a brushless motor driver. It watches two supply comparator levels, one for undervoltage and one for overvoltage. They arrive already synchronized, and the overvoltage level is picked from a low and a high comparator by a threshold-select bit. From these levels the block drives an active-low, open-drain style fault pull-down and a motor-driver disable. It also keeps a small register of sticky fault bits that software reads and clears by writing zeros.

When overvoltage appears, the block forces the output stage into asynchronous rectification. Once the condition clears, it holds that mode for a fixed 60 µs. The hold is counted in clock cycles from a clock-frequency parameter. After the hold, the stage returns to whatever rectification mode software has configured. A standby enable gates the external power switch and the internal regulator. The synchronous active-low reset acts as the deep supply reset and clears all state.

Top module: `mdrv_fault_sup`

## Requirements
- R1: `fault_pull_lo` is 1 (drive the fault line low) in the same cycle that the undervoltage level or the selected overvoltage level is 1, and is 0 (released) otherwise.
- R2: `drv_disable` is 1 exactly while `uv_lvl` is 1 and returns to 0 as soon as it drops, with no register write needed.
- R3: With `ovth_sel`=0 the overvoltage condition is `ov_lo_lvl`, and with `ovth_sel`=1 it is `ov_hi_lvl`. The comparator that is not selected has no effect on any output or on the fault register.
- R4: The fault register `fault_rd` has bit 0 for undervoltage and bit 1 for overvoltage. A bit reads 1 from the clock edge after its condition is seen, and it stays 1 for as long as the condition lasts.
- R5: A set fault bit stays set until a cycle with `clr_wr`=1 and a 0 in that bit of `clr_data`; that write clears it at the next edge. Writing a 1 leaves the bit unchanged.
- R6: A clear write made while the bit's condition is still present is overridden, and the bit stays 1. Writes to the other bit still work during undervoltage.
- R7: After reset the fault register reads 2'b01 (undervoltage bit set), and no rectification hold is pending.
- R8: While the selected overvoltage condition is present, `sync_rect_on` is 0 whatever the value of `sync_rect_cfg`.
- R9: After overvoltage goes away, `sync_rect_on` stays 0 for exactly DELAY_CYC = CLK_HZ/1e6*60 clock edges and then follows `sync_rect_cfg`. If `sync_rect_cfg` is 0 it stays 0.
- R10: An overvoltage that arrives while the hold is running restarts the full hold once it clears again.
- R11: `vsw_on` and `vreg_on` both equal `stby_en`: off in standby, on when enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low supply reset |
| stby_en | input | 1 | Enable; 0 selects standby |
| uv_lvl | input | 1 | Undervoltage comparator level |
| ov_lo_lvl | input | 1 | Overvoltage comparator, lower threshold |
| ov_hi_lvl | input | 1 | Overvoltage comparator, upper threshold |
| ovth_sel | input | 1 | Threshold select: 0 lower, 1 upper |
| sync_rect_cfg | input | 1 | Software synchronous-rectification enable |
| clr_wr | input | 1 | Fault register write strobe |
| clr_data | input | 2 | Write data; a 0 bit clears that fault |
| fault_pull_lo | output | 1 | 1 drives the fault line low, 0 releases it |
| drv_disable | output | 1 | Motor driver disable |
| sync_rect_on | output | 1 | Effective synchronous rectification |
| vsw_on | output | 1 | External power switch enable |
| vreg_on | output | 1 | Internal regulator enable |
| fault_rd | output | 2 | Sticky fault register |

## Verification
The bench goes after the edges of the rectification hold by sampling one cycle before it expires and again at the expiry edge. An off-by-one counter would restore synchronous mode a cycle early or a cycle late. The bench also re-triggers overvoltage halfway through the hold. A counter that only counts down without reloading would release the hold too soon. It sweeps every combination of comparator levels with the threshold select, where a swapped mux would report faults from the wrong comparator. It also combines every clear pattern with live conditions. A register that lets a clear win over a present condition, or that treats a written 1 as a clear, would show the wrong bits.

// File: rtl/mfs_pkg.sv
// Shared definitions for the motor driver fault supervisor.
// Assumes two fault sources; bit positions are read by software.
package mfs_pkg;
    localparam int FLT_W      = 2;
    localparam int FLT_UV_BIT = 0;
    localparam int FLT_OV_BIT = 1;
    localparam logic [FLT_W-1:0] FLT_RST_VAL = 2'b01;
    typedef logic [FLT_W-1:0] flt_vec_t;
endpackage

// File: rtl/mfs_sticky_reg.sv
// Sticky fault register: each bit sets while its condition is present,
// and clears only on a write carrying a 0 in that bit.
// Assumes conditions are synchronous levels; a present condition wins over a clear.
module mfs_sticky_reg #(
    parameter int N = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond,
    input  logic         wr_en,
    input  logic [N-1:0] wr_data,
    output logic [N-1:0] flt_q
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic clr;
            // clear request: a write carrying a zero in this bit
            always_comb clr = wr_en && !wr_data[i];

            // bit register: set by condition, cleared by zero-write
            always_ff @(posedge clk) begin
                if (!rst_n) flt_q[i] <= RST_VAL[i];
                else        flt_q[i] <= (flt_q[i] && !clr) || cond[i];
            end

            assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
                flt_q[i] && !(wr_en && !wr_data[i]) |=> flt_q[i]);
            assert_set_on_cond_R4: assert property (@(posedge clk) disable iff (!rst_n)
                cond[i] |=> flt_q[i]);
            assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en && !wr_data[i] && !cond[i] |=> !flt_q[i]);
        end
    endgenerate
endmodule

// File: rtl/mfs_rect_ctrl.sv
// Rectification controller: forces asynchronous mode during overvoltage
// and for DELAY_CYC clock edges after it clears, then follows software.
// Assumes ov is a synchronous level; a new event during the hold reloads it.
module mfs_rect_ctrl #(
    parameter int DELAY_CYC = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ov,
    input  logic sync_cfg,
    output logic sync_on
);
    localparam int CW = $clog2(DELAY_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(DELAY_CYC);

    logic [CW-1:0] hold_cnt;
    logic          busy;

    // hold counter: reload on overvoltage, count down after it clears
    always_ff @(posedge clk) begin
        if (!rst_n)              hold_cnt <= '0;
        else if (ov)             hold_cnt <= LOAD;
        else if (hold_cnt != 0)  hold_cnt <= hold_cnt - 1'b1;
    end

    // hold active whenever the counter has time left
    always_comb busy = (hold_cnt != 0);

    // effective mode: synchronous only when allowed and configured
    always_comb sync_on = sync_cfg && !ov && !busy;

    assert_async_on_ov_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ov |-> !sync_on);
    assert_hold_after_ov_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ov |=> !sync_on);
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= LOAD);
    assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ov |=> hold_cnt == LOAD);
endmodule

// File: rtl/mdrv_fault_sup.sv
// Motor driver fault supervisor top: selects the overvoltage comparator,
// drives the fault pull-down and driver disable, gates standby supplies,
// and holds the sticky fault register and the rectification controller.
// Assumes all comparator levels are already synchronized to clk.
module mdrv_fault_sup #(
    parameter int CLK_HZ   = 250_000_000,
    parameter int DELAY_US = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stby_en,
    input  logic       uv_lvl,
    input  logic       ov_lo_lvl,
    input  logic       ov_hi_lvl,
    input  logic       ovth_sel,
    input  logic       sync_rect_cfg,
    input  logic       clr_wr,
    input  logic [1:0] clr_data,
    output logic       fault_pull_lo,
    output logic       drv_disable,
    output logic       sync_rect_on,
    output logic       vsw_on,
    output logic       vreg_on,
    output logic [1:0] fault_rd
);
    import mfs_pkg::*;

    localparam int DELAY_CYC = (CLK_HZ / 1_000_000) * DELAY_US;

    logic     ov_sel;
    flt_vec_t cond_vec;

    // pick the comparator that matches the selected threshold
    always_comb ov_sel = ovth_sel ? ov_hi_lvl : ov_lo_lvl;

    // gather conditions in register bit order
    always_comb begin
        cond_vec             = '0;
        cond_vec[FLT_UV_BIT] = uv_lvl;
        cond_vec[FLT_OV_BIT] = ov_sel;
    end

    // fault line and driver disable follow live conditions
    always_comb begin
        fault_pull_lo = uv_lvl || ov_sel;
        drv_disable   = uv_lvl;
    end

    // standby gating of switch and regulator
    always_comb begin
        vsw_on  = stby_en;
        vreg_on = stby_en;
    end

    mfs_sticky_reg #(.N(FLT_W), .RST_VAL(FLT_RST_VAL)) u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cond    (cond_vec),
        .wr_en   (clr_wr),
        .wr_data (clr_data),
        .flt_q   (fault_rd)
    );

    mfs_rect_ctrl #(.DELAY_CYC(DELAY_CYC)) u_rect (
        .clk      (clk),
        .rst_n    (rst_n),
        .ov       (ov_sel),
        .sync_cfg (sync_rect_cfg),
        .sync_on  (sync_rect_on)
    );

    assert_uv_logged_R4: assert property (@(posedge clk) disable iff (!rst_n)
        uv_lvl |=> fault_rd[FLT_UV_BIT]);
    assert_no_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_lvl || ov_sel) |-> fault_pull_lo);
    assert_uv_async_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_lvl && !ov_sel |-> !fault_pull_lo && !drv_disable);
endmodule

// File: tb/mdrv_fault_sup_tb_top.sv
module mdrv_fault_sup_tb_top;
    localparam int CLK_HZ = 1_000_000;
    localparam int D      = 60;

    logic clk = 0, rst_n = 0;
    logic stby_en = 0, uv_lvl = 0, ov_lo_lvl = 0, ov_hi_lvl = 0, ovth_sel = 0;
    logic sync_rect_cfg = 0, clr_wr = 0;
    logic [1:0] clr_data = 2'b11;
    logic fault_pull_lo, drv_disable, sync_rect_on, vsw_on, vreg_on;
    logic [1:0] fault_rd;
    int errs = 0, checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mdrv_fault_sup #(.CLK_HZ(CLK_HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .stby_en(stby_en), .uv_lvl(uv_lvl),
        .ov_lo_lvl(ov_lo_lvl), .ov_hi_lvl(ov_hi_lvl), .ovth_sel(ovth_sel),
        .sync_rect_cfg(sync_rect_cfg), .clr_wr(clr_wr), .clr_data(clr_data),
        .fault_pull_lo(fault_pull_lo), .drv_disable(drv_disable),
        .sync_rect_on(sync_rect_on), .vsw_on(vsw_on), .vreg_on(vreg_on),
        .fault_rd(fault_rd));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [1:0] model;
        // R7: reset state
        repeat (3) step();
        rst_n = 1; sync_rect_cfg = 1; #1;
        chk(fault_rd == 2'b01, "R7 reset reg", fault_rd, 1);
        chk(sync_rect_on == 1, "R7 no hold after reset", sync_rect_on, 1);

        // R5: writing 1 to UV keeps it; writing 0 clears; OV written 1 stays 0
        clr_wr = 1; clr_data = 2'b11; step();
        chk(fault_rd == 2'b01, "R5 write one no effect", fault_rd, 1);
        clr_data = 2'b10; step(); clr_wr = 0; clr_data = 2'b11;
        chk(fault_rd == 2'b00, "R5 zero write clears", fault_rd, 0);

        // R1 R2 R3 R11 R8: sweep of levels, select and enable
        for (int v = 0; v < 64; v++) begin
            logic e_ov;
            {uv_lvl, ov_lo_lvl, ov_hi_lvl, ovth_sel, stby_en, sync_rect_cfg} = 6'(v);
            #1;
            e_ov = ovth_sel ? ov_hi_lvl : ov_lo_lvl;
            chk(fault_pull_lo == (uv_lvl | e_ov), "R1 R3 fault line", fault_pull_lo, uv_lvl | e_ov);
            chk(drv_disable == uv_lvl, "R2 disable", drv_disable, uv_lvl);
            chk(vsw_on == stby_en && vreg_on == stby_en, "R11 standby", {vsw_on, vreg_on}, {2{stby_en}});
            if (e_ov) chk(sync_rect_on == 0, "R8 async during ov", sync_rect_on, 0);
            step();
            chk(fault_rd[1] == e_ov || fault_rd[1] == 1'b1, "R4 ov logged", fault_rd[1], e_ov);
            chk(fault_rd[0] == 1'b1 || !uv_lvl, "R4 uv logged", fault_rd[0], 1);
        end

        // R4 R5 R6: sticky model sweep over conditions and writes
        uv_lvl = 0; ov_lo_lvl = 0; ov_hi_lvl = 0; ovth_sel = 0;
        clr_wr = 1; clr_data = 2'b00; step(); clr_wr = 0; step();
        model = 2'b00;
        chk(fault_rd == model, "R5 cleared both", fault_rd, model);
        for (int v = 0; v < 128; v++) begin
            logic [1:0] cnd;
            {ovth_sel, uv_lvl, ov_lo_lvl, clr_wr, clr_data} = 6'(v * 7 + v / 3);
            ov_hi_lvl = ov_lo_lvl;
            cnd = {ov_lo_lvl, uv_lvl};
            model = (model & ~(clr_wr ? ~clr_data : 2'b00)) | cnd;
            step();
            chk(fault_rd == model, "R4 R5 R6 sticky", fault_rd, model);
        end
        // R6: clear during live UV is overridden while OV clears
        uv_lvl = 1; ov_lo_lvl = 0; ov_hi_lvl = 0; clr_wr = 1; clr_data = 2'b00;
        step(); step(); clr_wr = 0;
        chk(fault_rd == 2'b01, "R6 clear overridden, other bit works", fault_rd, 1);
        uv_lvl = 0; clr_wr = 1; step(); clr_wr = 0; clr_data = 2'b11;
        chk(fault_rd == 2'b00, "R6 clear after recovery", fault_rd, 0);

        // R3: unselected comparator ignored
        ovth_sel = 1; ov_lo_lvl = 1; ov_hi_lvl = 0; sync_rect_cfg = 1;
        repeat (D + 2) step();
        chk(fault_pull_lo == 0 && fault_rd == 2'b00 && sync_rect_on == 1,
            "R3 low comparator ignored", {fault_pull_lo, fault_rd, sync_rect_on}, 1);

        // R9: exact hold length
        ovth_sel = 0; ov_lo_lvl = 1; step(); step();
        chk(sync_rect_on == 0, "R8 forced async", sync_rect_on, 0);
        ov_lo_lvl = 0;
        for (int k = 1; k < D; k++) begin
            step();
            if (sync_rect_on != 0) chk(0, "R9 early restore", k, D);
        end
        #1 chk(sync_rect_on == 0, "R9 held at D-1", sync_rect_on, 0);
        step();
        chk(sync_rect_on == 1, "R9 restored at D", sync_rect_on, 1);

        // R10: retrigger during hold restarts it
        ov_lo_lvl = 1; step(); ov_lo_lvl = 0;
        repeat (20) step();
        ov_lo_lvl = 1; step(); ov_lo_lvl = 0;
        repeat (D - 1) step();
        chk(sync_rect_on == 0, "R10 restart still held", sync_rect_on, 0);
        step();
        chk(sync_rect_on == 1, "R10 restored after full hold", sync_rect_on, 1);

        // R9: disabled config stays async after hold
        sync_rect_cfg = 0; ov_lo_lvl = 1; step(); ov_lo_lvl = 0;
        repeat (D + 5) step();
        chk(sync_rect_on == 0, "R9 disabled stays async", sync_rect_on, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule